// File: doc/BRIEF.md
# Write-Back Write-Allocate Set-Associative Cache Controller

This block is a parameterised set-associative cache controller meant to sit between an upstream requester (a processor or an inner cache) and a downstream level (an outer cache or main memory). Upstream read and write requests arrive over a valid/ready handshake, one at a time. A hit is answered from the tag store. A miss allocates a line for reads and for writes alike. The set is split as `SIZE_BYTES / (BLOCK_BYTES * WAYS)`. Both `BLOCK_BYTES` and the set count must be powers of two, and there must be at least two sets. `WAYS` can be any value of 1 or more, and 1 gives a direct-mapped cache.

Writes stay in the cache and set the line's dirty bit. Traffic goes downstream only on a miss. If the chosen victim is dirty, its writeback goes out first, and the block read for the fill follows. Each line carries one data word, which stands in for the block payload. The victim is chosen by true LRU or by tree pseudo-LRU, selected with `REPL_MODE`. Tree mode needs a power-of-two `WAYS`.

Top module: `wbwa_cache`

## Requirements
- R1: The address is split into three fields. The low `log2(BLOCK_BYTES)` bits are the offset, the next `log2(sets)` bits select the set, and the remaining upper bits are the tag. Every downstream address has an all-zero offset field.
- R2: A read miss issues one downstream read (`dn_write_o`=0) for the requested block. It then installs the line, so a later access to the same block hits.
- R3: A write miss allocates the line just as a read miss does, and the line is then dirty. A write hit updates the line and sends nothing downstream.
- R4: On a miss, if the set holds an invalid way, the lowest-numbered invalid way is filled and nothing is evicted. After reset, `WAYS` distinct blocks in one set all stay resident.
- R5: When every way is valid and the victim is dirty, a writeback (`dn_write_o`=1) carries the victim's block address and word. It completes before the fill read is requested.
- R6: A clean victim is dropped without any downstream write. Only the fill read is issued.
- R7: With `REPL_MODE`=0, the victim is the least recently touched way. Both hits and fills count as touches.
- R8: With `REPL_MODE`=1, each set keeps `WAYS-1` tree bits. A touch sets every node on the path to point away from the touched way. The victim is found by following the node bits from the root, where 0 means the left half and 1 means the right half.
- R9: While `dn_valid_o` is high and `dn_ready_i` is low, the request stays valid and `dn_addr_o`, `dn_write_o` and `dn_wdata_o` stay stable.
- R10: `req_ready_o` drops on the cycle after a request is accepted and returns only after the response. `resp_valid_o` is a one-cycle pulse. For a miss, it comes in the cycle after `dn_rvalid_i`.
- R11: `resp_hit_o` reports whether the access hit. `resp_rdata_o` returns the line's word after the access: the written word for writes, and the most recently written value of the block for reads.
- R12: After reset, `req_ready_o` is 1, `dn_valid_o` and `resp_valid_o` are 0, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Upstream request valid |
| req_ready_o | output | 1 | Controller idle and able to accept a request |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_wdata_i | input | DATA_W | Write word |
| resp_valid_o | output | 1 | Response pulse |
| resp_hit_o | output | 1 | Access hit in the cache |
| resp_rdata_o | output | DATA_W | Line word after the access |
| dn_valid_o | output | 1 | Downstream request valid |
| dn_ready_i | input | 1 | Downstream accepts the request |
| dn_write_o | output | 1 | 1 for a writeback, 0 for a fill read |
| dn_addr_o | output | ADDR_W | Block-aligned downstream address |
| dn_wdata_o | output | DATA_W | Writeback word |
| dn_rvalid_i | input | 1 | Fill data valid |
| dn_rdata_i | input | DATA_W | Fill word |

## Verification
Two downstream transactions can be pending back to back: the writeback of a dirty victim and the fill read that follows it. The writeback handshake and the start of the fill request fall in neighbouring cycles. To provoke them, the bench writes many distinct blocks into a small tag pool, so dirty evictions keep recurring. Meanwhile the downstream model drops ready at random and returns fill data after a random delay. The model stamps each handshake with a sequence number, so each access can be judged on three points: whether the writeback was issued at all, its address and word, and whether it came strictly before the fill. Two controller instances, one per replacement mode, run the same stimulus and are compared against a bench reference model.

// File: rtl/wbwa_cache_pkg.sv
package wbwa_cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WB,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_RESP
  } ctrl_state_e;

  localparam int REPL_LRU  = 0;
  localparam int REPL_PLRU = 1;

  function automatic int clog2_min1(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/wbwa_cache_tags.sv
module wbwa_cache_tags #(
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 10,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2,
  parameter int WAY_W  = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [IDX_W-1:0]               rd_set_i,
  output logic [WAYS-1:0][TAG_W-1:0]     rd_tag_o,
  output logic [WAYS-1:0]                rd_valid_o,
  output logic [WAYS-1:0]                rd_dirty_o,
  output logic [WAYS-1:0][DATA_W-1:0]    rd_data_o,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_set_i,
  input  logic [WAY_W-1:0]               wr_way_i,
  input  logic [TAG_W-1:0]               wr_tag_i,
  input  logic                           wr_dirty_i,
  input  logic [DATA_W-1:0]              wr_data_i
);

  logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
  logic [WAYS-1:0]             valid_q [SETS];
  logic [WAYS-1:0]             dirty_q [SETS];
  logic [WAYS-1:0][DATA_W-1:0] data_q  [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]   <= '0;
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        data_q[s]  <= '0;
      end
    end else if (wr_en_i) begin
      tag_q[wr_set_i][wr_way_i]   <= wr_tag_i;
      valid_q[wr_set_i][wr_way_i] <= 1'b1;
      dirty_q[wr_set_i][wr_way_i] <= wr_dirty_i;
      data_q[wr_set_i][wr_way_i]  <= wr_data_i;
    end
  end

  assign rd_tag_o   = tag_q[rd_set_i];
  assign rd_valid_o = valid_q[rd_set_i];
  assign rd_dirty_o = dirty_q[rd_set_i];
  assign rd_data_o  = data_q[rd_set_i];

endmodule

// File: rtl/wbwa_cache_waysel.sv
module wbwa_cache_waysel #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 10,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           req_tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o,
  output logic                       free_o,
  output logic [WAY_W-1:0]           free_way_o
);

  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tag_i[w] == req_tag_i);
  end

  always_comb begin
    hit_o      = |match;
    free_o     = ~&valid_i;
    hit_way_o  = '0;
    free_way_o = '0;
    // descending scan so the lowest index wins
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w])    hit_way_o  = WAY_W'(w);
      if (!valid_i[w]) free_way_o = WAY_W'(w);
    end
  end

endmodule

// File: rtl/wbwa_cache_repl.sv
module wbwa_cache_repl
  import wbwa_cache_pkg::*;
#(
  parameter int SETS      = 4,
  parameter int WAYS      = 4,
  parameter int IDX_W     = 2,
  parameter int WAY_W     = 2,
  parameter int REPL_MODE = REPL_LRU
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [IDX_W-1:0] query_set_i,
  output logic [WAY_W-1:0] victim_o
);

  if (REPL_MODE == REPL_PLRU) begin : g_plru
    localparam int LVL    = (WAYS > 1) ? $clog2(WAYS) : 0;
    localparam int NODES  = (WAYS > 1) ? WAYS - 1 : 1;
    localparam int NODE_W = clog2_min1(NODES) + 1;

    logic [NODES-1:0] tree_q [SETS];
    logic [NODES-1:0] tree_upd;

    always_comb begin
      logic [NODE_W-1:0] node;
      logic              dir;
      tree_upd = tree_q[touch_set_i];
      node     = '0;
      for (int l = 0; l < LVL; l++) begin
        dir            = touch_way_i[LVL-1-l];
        tree_upd[node] = ~dir;
        node           = (node << 1) + NODE_W'(1) + NODE_W'(dir);
      end
    end

    always_comb begin
      logic [NODES-1:0]  t;
      logic [NODE_W-1:0] node;
      logic              b;
      t        = tree_q[query_set_i];
      node     = '0;
      victim_o = '0;
      for (int l = 0; l < LVL; l++) begin
        b        = t[node];
        victim_o = (victim_o << 1) | WAY_W'(b);
        node     = (node << 1) + NODE_W'(1) + NODE_W'(b);
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
      end else if (touch_i) begin
        tree_q[touch_set_i] <= tree_upd;
      end
    end
  end else begin : g_lru
    localparam int AGE_W = clog2_min1(WAYS);

    logic [WAYS-1:0][AGE_W-1:0] age_q [SETS];
    logic [WAYS-1:0][AGE_W-1:0] age_upd;
    logic [WAYS-1:0][AGE_W-1:0] age_rd;

    always_comb begin
      logic [AGE_W-1:0] ref_age;
      age_upd = age_q[touch_set_i];
      ref_age = age_upd[touch_way_i];
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i) age_upd[w] = '0;
        else if (age_upd[w] < ref_age) age_upd[w] = age_upd[w] + AGE_W'(1);
      end
    end

    always_comb begin
      age_rd   = age_q[query_set_i];
      victim_o = '0;
      for (int w = 0; w < WAYS; w++) begin
        if (age_rd[w] == AGE_W'(WAYS - 1)) victim_o = WAY_W'(w);
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
      end else if (touch_i) begin
        age_q[touch_set_i] <= age_upd;
      end
    end
  end

endmodule

// File: rtl/wbwa_cache.sv
module wbwa_cache
  import wbwa_cache_pkg::*;
#(
  parameter int SIZE_BYTES  = 256,
  parameter int BLOCK_BYTES = 16,
  parameter int WAYS        = 4,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int REPL_MODE   = REPL_LRU
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic              dn_valid_o,
  input  logic              dn_ready_i,
  output logic              dn_write_o,
  output logic [ADDR_W-1:0] dn_addr_o,
  output logic [DATA_W-1:0] dn_wdata_o,
  input  logic              dn_rvalid_i,
  input  logic [DATA_W-1:0] dn_rdata_i
);

  localparam int SETS  = SIZE_BYTES / (BLOCK_BYTES * WAYS);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int TAG_W = BLK_W - IDX_W;
  localparam int WAY_W = clog2_min1(WAYS);

  ctrl_state_e st_q, st_d;

  logic              op_write_q;
  logic [BLK_W-1:0]  blk_q;
  logic [DATA_W-1:0] wdata_q;
  logic [WAY_W-1:0]  way_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic [DATA_W-1:0] wb_data_q;
  logic              resp_hit_q;
  logic [DATA_W-1:0] resp_data_q;

  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_set;
  logic             unused_off;

  logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
  logic [WAYS-1:0]             rd_valid;
  logic [WAYS-1:0]             rd_dirty;
  logic [WAYS-1:0][DATA_W-1:0] rd_data;

  logic              hit, free;
  logic [WAY_W-1:0]  hit_way, free_way, victim_way, tgt_way;
  logic              wr_en, wr_dirty, touch;
  logic [WAY_W-1:0]  wr_way, touch_way;
  logic [DATA_W-1:0] wr_data;

  assign req_tag    = blk_q[BLK_W-1 -: TAG_W];
  assign req_set    = blk_q[IDX_W-1:0];
  assign unused_off = ^req_addr_i[OFF_W-1:0];
  assign tgt_way    = free ? free_way : victim_way;

  wbwa_cache_tags #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_set_i   (req_set),
    .rd_tag_o   (rd_tag),
    .rd_valid_o (rd_valid),
    .rd_dirty_o (rd_dirty),
    .rd_data_o  (rd_data),
    .wr_en_i    (wr_en),
    .wr_set_i   (req_set),
    .wr_way_i   (wr_way),
    .wr_tag_i   (req_tag),
    .wr_dirty_i (wr_dirty),
    .wr_data_i  (wr_data)
  );

  wbwa_cache_waysel #(
    .WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)
  ) u_waysel (
    .tag_i      (rd_tag),
    .valid_i    (rd_valid),
    .req_tag_i  (req_tag),
    .hit_o      (hit),
    .hit_way_o  (hit_way),
    .free_o     (free),
    .free_way_o (free_way)
  );

  wbwa_cache_repl #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W),
    .REPL_MODE(REPL_MODE)
  ) u_repl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch),
    .touch_set_i (req_set),
    .touch_way_i (touch_way),
    .query_set_i (req_set),
    .victim_o    (victim_way)
  );

  always_comb begin
    st_d      = st_q;
    wr_en     = 1'b0;
    wr_way    = way_q;
    wr_dirty  = 1'b1;
    wr_data   = wdata_q;
    touch     = 1'b0;
    touch_way = way_q;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (hit) begin
          touch     = 1'b1;
          touch_way = hit_way;
          wr_en     = op_write_q;
          wr_way    = hit_way;
          st_d      = ST_RESP;
        end else if (!free && rd_dirty[victim_way]) begin
          st_d = ST_WB;
        end else begin
          st_d = ST_FILL_REQ;
        end
      end
      ST_WB:       if (dn_ready_i) st_d = ST_FILL_REQ;
      ST_FILL_REQ: if (dn_ready_i) st_d = ST_FILL_WAIT;
      ST_FILL_WAIT: begin
        if (dn_rvalid_i) begin
          wr_en    = 1'b1;
          wr_dirty = op_write_q;
          wr_data  = op_write_q ? wdata_q : dn_rdata_i;
          touch    = 1'b1;
          st_d     = ST_RESP;
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      op_write_q  <= 1'b0;
      blk_q       <= '0;
      wdata_q     <= '0;
      way_q       <= '0;
      wb_addr_q   <= '0;
      wb_data_q   <= '0;
      resp_hit_q  <= 1'b0;
      resp_data_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_valid_i) begin
        op_write_q <= req_write_i;
        blk_q      <= req_addr_i[ADDR_W-1:OFF_W];
        wdata_q    <= req_wdata_i;
      end
      if (st_q == ST_LOOKUP) begin
        resp_hit_q <= hit;
        if (hit) begin
          resp_data_q <= op_write_q ? wdata_q : rd_data[hit_way];
        end else begin
          way_q     <= tgt_way;
          wb_addr_q <= {rd_tag[victim_way], req_set, {OFF_W{1'b0}}};
          wb_data_q <= rd_data[victim_way];
        end
      end
      if (st_q == ST_FILL_WAIT && dn_rvalid_i) resp_data_q <= wr_data;
    end
  end

  assign req_ready_o  = (st_q == ST_IDLE);
  assign resp_valid_o = (st_q == ST_RESP);
  assign resp_hit_o   = resp_hit_q;
  assign resp_rdata_o = resp_data_q;
  assign dn_valid_o   = (st_q == ST_WB) || (st_q == ST_FILL_REQ);
  assign dn_write_o   = (st_q == ST_WB);
  assign dn_addr_o    = (st_q == ST_WB) ? wb_addr_q : {blk_q, {OFF_W{1'b0}}};
  assign dn_wdata_o   = (st_q == ST_WB) ? wb_data_q : '0;

endmodule

// File: rtl/wbwa_cache_chk.sv
module wbwa_cache_chk #(
  parameter int BLOCK_BYTES = 16,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              resp_valid_o,
  input logic              resp_hit_o,
  input logic              dn_valid_o,
  input logic              dn_ready_i,
  input logic              dn_write_o,
  input logic [ADDR_W-1:0] dn_addr_o,
  input logic [DATA_W-1:0] dn_wdata_o,
  input logic              dn_rvalid_i
);

  localparam int OFF_W = $clog2(BLOCK_BYTES);

  // R1
  dn_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |-> (dn_addr_o[OFF_W-1:0] == '0));

  // R5
  wb_before_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o && dn_ready_i && dn_write_o |=> dn_valid_o && !dn_write_o);

  // R9
  dn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o && !dn_ready_i |=> dn_valid_o && $stable(dn_addr_o)
      && $stable(dn_write_o) && $stable(dn_wdata_o));

  // R10
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  // R10
  resp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);

  // R10
  miss_resp_after_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && !resp_hit_o |-> $past(dn_rvalid_i));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !dn_valid_o && !resp_valid_o);

endmodule

bind wbwa_cache wbwa_cache_chk #(
  .BLOCK_BYTES(BLOCK_BYTES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .resp_valid_o (resp_valid_o),
  .resp_hit_o   (resp_hit_o),
  .dn_valid_o   (dn_valid_o),
  .dn_ready_i   (dn_ready_i),
  .dn_write_o   (dn_write_o),
  .dn_addr_o    (dn_addr_o),
  .dn_wdata_o   (dn_wdata_o),
  .dn_rvalid_i  (dn_rvalid_i)
);

// File: tb/wbwa_cache_mem.sv
module wbwa_cache_mem #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dn_valid,
  output logic              dn_ready,
  input  logic              dn_write,
  input  logic [ADDR_W-1:0] dn_addr,
  input  logic [DATA_W-1:0] dn_wdata,
  output logic              dn_rvalid,
  output logic [DATA_W-1:0] dn_rdata,
  output int                wb_cnt,
  output int                fill_cnt,
  output int                wb_seq,
  output int                fill_seq,
  output logic [ADDR_W-1:0] last_wb_addr,
  output logic [DATA_W-1:0] last_wb_data,
  output logic [ADDR_W-1:0] last_fill_addr
);

  logic [DATA_W-1:0] store [logic [ADDR_W-1:0]];
  int                evt;
  int                dly;
  logic              pend;
  logic [ADDR_W-1:0] paddr;

  function automatic logic [DATA_W-1:0] init_word(input logic [ADDR_W-1:0] a);
    return DATA_W'((32'(a >> OFF_W)) * 32'h0100_0193 ^ 32'hC3A5_0000);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_ready <= 1'b0; dn_rvalid <= 1'b0; dn_rdata <= '0;
      wb_cnt <= 0; fill_cnt <= 0; wb_seq <= 0; fill_seq <= 0; evt <= 1;
      last_wb_addr <= '0; last_wb_data <= '0; last_fill_addr <= '0;
      pend <= 1'b0; dly <= 0; paddr <= '0;
    end else begin
      dn_ready  <= ($urandom % 4) != 0;
      dn_rvalid <= 1'b0;
      if (dn_valid && dn_ready) begin
        evt <= evt + 1;
        if (dn_write) begin
          store[dn_addr] = dn_wdata;
          wb_cnt       <= wb_cnt + 1;
          wb_seq       <= evt;
          last_wb_addr <= dn_addr;
          last_wb_data <= dn_wdata;
        end else begin
          fill_cnt       <= fill_cnt + 1;
          fill_seq       <= evt;
          last_fill_addr <= dn_addr;
          pend           <= 1'b1;
          paddr          <= dn_addr;
          dly            <= int'($urandom % 3);
        end
      end else if (pend) begin
        if (dly == 0) begin
          pend      <= 1'b0;
          dn_rvalid <= 1'b1;
          dn_rdata  <= store.exists(paddr) ? store[paddr] : init_word(paddr);
        end else begin
          dly <= dly - 1;
        end
      end
    end
  end

endmodule

// File: tb/wbwa_cache_bench.sv
module wbwa_cache_bench;

  localparam int SIZE_BYTES  = 256;
  localparam int BLOCK_BYTES = 16;
  localparam int WAYS        = 4;
  localparam int ADDR_W      = 16;
  localparam int DATA_W      = 32;
  localparam int SETS        = SIZE_BYTES / (BLOCK_BYTES * WAYS);
  localparam int OFF_W       = $clog2(BLOCK_BYTES);
  localparam int IDX_W       = $clog2(SETS);
  localparam int TAG_W       = ADDR_W - OFF_W - IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;

  logic [1:0]              req_ready, resp_valid, resp_hit;
  logic [1:0][DATA_W-1:0]  resp_rdata;
  logic [1:0]              dn_valid, dn_ready, dn_write, dn_rvalid;
  logic [1:0][ADDR_W-1:0]  dn_addr, last_wb_addr, last_fill_addr;
  logic [1:0][DATA_W-1:0]  dn_wdata, dn_rdata, last_wb_data;
  int wb_cnt [2];
  int fill_cnt [2];
  int wb_seq [2];
  int fill_seq [2];

  int n_cmp = 0;
  int n_mis = 0;

  wbwa_cache #(.SIZE_BYTES(SIZE_BYTES), .BLOCK_BYTES(BLOCK_BYTES), .WAYS(WAYS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REPL_MODE(0)) u_wbwa_cache (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready[0]),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .resp_valid_o(resp_valid[0]), .resp_hit_o(resp_hit[0]), .resp_rdata_o(resp_rdata[0]),
    .dn_valid_o(dn_valid[0]), .dn_ready_i(dn_ready[0]), .dn_write_o(dn_write[0]),
    .dn_addr_o(dn_addr[0]), .dn_wdata_o(dn_wdata[0]), .dn_rvalid_i(dn_rvalid[0]),
    .dn_rdata_i(dn_rdata[0]));

  wbwa_cache #(.SIZE_BYTES(SIZE_BYTES), .BLOCK_BYTES(BLOCK_BYTES), .WAYS(WAYS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REPL_MODE(1)) u_wbwa_cache_plru (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready[1]),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .resp_valid_o(resp_valid[1]), .resp_hit_o(resp_hit[1]), .resp_rdata_o(resp_rdata[1]),
    .dn_valid_o(dn_valid[1]), .dn_ready_i(dn_ready[1]), .dn_write_o(dn_write[1]),
    .dn_addr_o(dn_addr[1]), .dn_wdata_o(dn_wdata[1]), .dn_rvalid_i(dn_rvalid[1]),
    .dn_rdata_i(dn_rdata[1]));

  for (genvar g = 0; g < 2; g++) begin : g_side
    wbwa_cache_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .dn_valid(dn_valid[g]), .dn_ready(dn_ready[g]),
      .dn_write(dn_write[g]), .dn_addr(dn_addr[g]), .dn_wdata(dn_wdata[g]),
      .dn_rvalid(dn_rvalid[g]), .dn_rdata(dn_rdata[g]),
      .wb_cnt(wb_cnt[g]), .fill_cnt(fill_cnt[g]), .wb_seq(wb_seq[g]), .fill_seq(fill_seq[g]),
      .last_wb_addr(last_wb_addr[g]), .last_wb_data(last_wb_data[g]),
      .last_fill_addr(last_fill_addr[g]));
  end

  // captured responses
  int                     rsp_cnt [2];
  logic [1:0]             got_hit;
  logic [1:0][DATA_W-1:0] got_data;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_cnt[0] <= 0; rsp_cnt[1] <= 0; got_hit <= '0; got_data <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (resp_valid[p]) begin
          rsp_cnt[p]  <= rsp_cnt[p] + 1;
          got_hit[p]  <= resp_hit[p];
          got_data[p] <= resp_rdata[p];
        end
      end
    end
  end

  // reference model
  logic [TAG_W-1:0]  m_tag   [2][SETS][WAYS];
  bit                m_valid [2][SETS][WAYS];
  bit                m_dirty [2][SETS][WAYS];
  logic [DATA_W-1:0] m_data  [2][SETS][WAYS];
  int                m_age   [2][SETS][WAYS];
  bit                m_tree  [2][SETS][WAYS];
  logic [DATA_W-1:0] golden  [int];
  bit                last_hit [2];
  bit                last_wb  [2];

  function automatic logic [DATA_W-1:0] init_word(input logic [ADDR_W-1:0] a);
    return DATA_W'((32'(a >> OFF_W)) * 32'h0100_0193 ^ 32'hC3A5_0000);
  endfunction

  task automatic model_reset();
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          m_valid[p][s][w] = 0; m_dirty[p][s][w] = 0; m_tag[p][s][w] = '0;
          m_data[p][s][w] = '0; m_age[p][s][w] = w; m_tree[p][s][w] = 0;
        end
  endtask

  task automatic model_touch(input int p, input int s, input int way);
    if (p == 0) begin
      int ref_age = m_age[p][s][way];
      for (int w = 0; w < WAYS; w++)
        if (w != way && m_age[p][s][w] < ref_age) m_age[p][s][w]++;
      m_age[p][s][way] = 0;
    end else begin
      int node = 0;
      for (int l = $clog2(WAYS) - 1; l >= 0; l--) begin
        int dir = (way >> l) & 1;
        m_tree[p][s][node] = (dir == 0);
        node = 2 * node + 1 + dir;
      end
    end
  endtask

  function automatic int model_victim(input int p, input int s);
    int v = 0;
    if (p == 0) begin
      for (int w = 0; w < WAYS; w++) if (m_age[p][s][w] == WAYS - 1) v = w;
    end else begin
      int node = 0;
      for (int l = 0; l < $clog2(WAYS); l++) begin
        int b = int'(m_tree[p][s][node]);
        v = 2 * v + b;
        node = 2 * node + 1 + b;
      end
    end
    return v;
  endfunction

  task automatic model_access(input int p, input bit w, input logic [ADDR_W-1:0] a,
                              input logic [DATA_W-1:0] d, output bit hit, output bit wb,
                              output logic [ADDR_W-1:0] wb_a, output logic [DATA_W-1:0] wb_d,
                              output logic [DATA_W-1:0] rd);
    int s = int'(a[OFF_W +: IDX_W]);
    logic [TAG_W-1:0] t = a[ADDR_W-1 -: TAG_W];
    int blk = int'(a >> OFF_W);
    int way = -1;
    hit = 0; wb = 0; wb_a = '0; wb_d = '0;
    for (int i = 0; i < WAYS; i++)
      if (m_valid[p][s][i] && m_tag[p][s][i] == t) begin hit = 1; way = i; end
    if (!hit) begin
      for (int i = WAYS - 1; i >= 0; i--) if (!m_valid[p][s][i]) way = i;
      if (way < 0) begin
        way = model_victim(p, s);
        if (m_dirty[p][s][way]) begin
          wb   = 1;
          wb_a = {m_tag[p][s][way], IDX_W'(s), {OFF_W{1'b0}}};
          wb_d = m_data[p][s][way];
        end
      end
      m_valid[p][s][way] = 1;
      m_tag[p][s][way]   = t;
      m_dirty[p][s][way] = 0;
      m_data[p][s][way]  = golden.exists(blk) ? golden[blk]
                         : init_word({a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}});
    end
    if (w) begin
      m_data[p][s][way]  = d;
      m_dirty[p][s][way] = 1;
      golden[blk] = d;
    end
    rd = m_data[p][s][way];
    model_touch(p, s, way);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    bit e_hit [2];
    bit e_wb [2];
    logic [ADDR_W-1:0] e_wba [2];
    logic [DATA_W-1:0] e_wbd [2];
    logic [DATA_W-1:0] e_rd [2];
    int c_rsp [2];
    int c_wb [2];
    int c_fill [2];
    for (int p = 0; p < 2; p++) begin
      model_access(p, w, a, d, e_hit[p], e_wb[p], e_wba[p], e_wbd[p], e_rd[p]);
      c_rsp[p] = rsp_cnt[p]; c_wb[p] = wb_cnt[p]; c_fill[p] = fill_cnt[p];
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    for (int p = 0; p < 2; p++) check("R10 ready low while busy", 64'(req_ready[p]), 64'd0);
    while (rsp_cnt[0] == c_rsp[0] || rsp_cnt[1] == c_rsp[1]) @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      last_hit[p] = got_hit[p];
      last_wb[p]  = (wb_cnt[p] != c_wb[p]);
      check(p == 0 ? "R7 hit/miss (lru)" : "R8 hit/miss (tree)", 64'(got_hit[p]), 64'(e_hit[p]));
      check("R11 response word", 64'(got_data[p]), 64'(e_rd[p]));
      check(e_wb[p] ? "R5 writeback count" : "R6 no writeback",
            64'(wb_cnt[p] - c_wb[p]), 64'(e_wb[p]));
      check(w ? "R3 fill count" : "R2 fill count",
            64'(fill_cnt[p] - c_fill[p]), 64'(!e_hit[p]));
      if (e_wb[p] && wb_cnt[p] != c_wb[p]) begin
        check("R5 writeback address", 64'(last_wb_addr[p]), 64'(e_wba[p]));
        check("R5 writeback word", 64'(last_wb_data[p]), 64'(e_wbd[p]));
        check("R5 writeback precedes fill", 64'(wb_seq[p] < fill_seq[p]), 64'd1);
      end
      if (!e_hit[p] && fill_cnt[p] != c_fill[p])
        check("R1 fill address", 64'(last_fill_addr[p]),
              64'({a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}));
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk_addr(input int tag, input int set, input int off);
    return {TAG_W'(tag), IDX_W'(set), OFF_W'(off)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_mis++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    model_reset();
    repeat (3) @(negedge clk);
    // R12 reset state
    for (int p = 0; p < 2; p++) begin
      check("R12 ready after reset", 64'(req_ready[p]), 64'd1);
      check("R12 dn idle after reset", 64'(dn_valid[p]), 64'd0);
      check("R12 no response after reset", 64'(resp_valid[p]), 64'd0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4: fill set 0 from invalid ways, then all resident
    for (int t = 0; t < WAYS; t++) access(1'b0, mk_addr(t, 0, t), '0);
    for (int t = 0; t < WAYS; t++) begin
      access(1'b0, mk_addr(t, 0, 3), '0);
      for (int p = 0; p < 2; p++) check("R4 resident after fill", 64'(last_hit[p]), 64'd1);
    end
    // R2 read then hit
    access(1'b0, mk_addr(9, 1, 0), '0);
    access(1'b0, mk_addr(9, 1, 8), '0);
    for (int p = 0; p < 2; p++) check("R2 read allocates", 64'(last_hit[p]), 64'd1);
    // R3 write miss then write hit
    access(1'b1, mk_addr(11, 1, 4), 32'hDEAD_0001);
    access(1'b1, mk_addr(11, 1, 4), 32'hDEAD_0002);
    for (int p = 0; p < 2; p++) check("R3 write hit", 64'(last_hit[p]), 64'd1);

    // R7/R8 divergence in set 2: fill 4, touch way0, miss, then probe
    for (int t = 0; t < WAYS; t++) access(1'b0, mk_addr(20 + t, 2, 0), '0);
    access(1'b0, mk_addr(20, 2, 0), '0);
    access(1'b0, mk_addr(30, 2, 0), '0);
    access(1'b0, mk_addr(21, 2, 0), '0);
    check("R7 lru evicted way1", 64'(last_hit[0]), 64'd0);
    check("R8 tree kept way1", 64'(last_hit[1]), 64'd1);

    // R5 dirty eviction in set 3
    for (int t = 0; t < WAYS; t++) access(1'b1, mk_addr(40 + t, 3, 0), 32'hA000_0000 + t);
    access(1'b0, mk_addr(50, 3, 0), '0);
    for (int p = 0; p < 2; p++) check("R5 dirty victim written", 64'(last_wb[p]), 64'd1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      bit w = ($urandom % 2) == 1;
      access(w, mk_addr(int'($urandom % 7), int'($urandom % SETS), int'($urandom % BLOCK_BYTES)),
             $urandom);
    end

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

endmodule